// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out one vector-length configuration instruction per accepted transfer. It takes a 32-bit instruction word, together with the current 64-bit vector state word. From these it works out a new maximum vector length (MVL) and a new vector length (VL). It then commits all of its results on one clock edge:

- the two lengths;
- a rewritten state word;
- an optional write of VL to a destination register;
- an optional update of a 4-bit condition field.

The instruction carries a 7-bit immediate with an implied plus-one, so it can request any length from 1 to 128. Three mode bits choose what changes:

- whether MVL is loaded;
- whether VL is loaded;
- whether the vertical-first flag is applied.

When both length-set bits are clear, the instruction only reads VL, with no side effect on vector state.

MVL and VL are held inside the unit as 8-bit values, so 128 is representable. The 7-bit VL field in the state word keeps only the low 7 bits.

Top module: `vlcfg_unit`

## Requirements
- R1: Instruction fields, LSB-0: immediate `insn[15:9]`, MVL-set `insn[8]`, VL-set `insn[7]`, vertical-first `insn[6]`, destination index `insn[25:21]`, record `insn[0]`; the requested length is the immediate plus one, so an encoded 0 gives 1.
- R2: When MVL-set is 1, MVL becomes the requested length; otherwise MVL keeps its value.
- R3: When VL-set is 1, VL becomes the smaller of the requested length and MVL as updated by the same instruction; otherwise VL keeps its value.
- R4: When MVL-set or VL-set is 1, `stateWe` is 1 and `stateOut` equals `stateIn` with bits [56:50] replaced by the low 7 bits of VL, bit 0 set to the vertical-first bit and bit 1 (persist) cleared.
- R5: When MVL-set and VL-set are both 0, MVL and VL are unchanged, `stateWe` is 0 and the vertical-first bit has no effect.
- R6: A nonzero destination index gives `gprWe`=1, `gprIdx` equal to that index and `gprData` equal to the new VL zero-extended to 64 bits; index 0 gives `gprWe`=0.
- R7: A record bit of 1 gives `crWe`=1 with `crData`[3:0] = {0, VL!=0, VL==0, overflow}, where overflow is always 0; a record bit of 0 gives `crWe`=0.
- R8: `inReady` is always 1; a transfer with `inValid` high commits on that edge, and `outValid` together with every write enable is high for exactly the following cycle and low after an idle edge.
- R9: After reset, MVL equals RESET_MVL (128), VL is 0, and `outValid` and all write enables are 0.
- R10: An encoded immediate of 127 gives length 128: `mvlOut`/`vlOut` read 128 while the state VL field holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Unit can accept (always 1) |
| insn | input | 32 | Instruction word |
| stateIn | input | 64 | Current vector state word |
| outValid | output | 1 | Results of the last accepted instruction are present |
| mvlOut | output | 8 | Current MVL |
| vlOut | output | 8 | Current VL |
| stateWe | output | 1 | State word write enable |
| stateOut | output | 64 | New state word |
| gprWe | output | 1 | Destination register write enable |
| gprIdx | output | 5 | Destination register index |
| gprData | output | 64 | Destination register data |
| crWe | output | 1 | Condition field write enable |
| crData | output | 4 | Condition field value {lt, gt, eq, so} |

## Verification
The assertions assume that `inValid` is 0 for the whole of reset. They also assume that the instruction word and state word are stable and defined in any cycle where `inValid` is high. No other restriction is placed on the inputs: every immediate, mode combination, destination index and state pattern is legal.

The bench drives inputs only between clock edges and lowers `inValid` once each transfer is done. It draws every field from `$urandom`, so all mode combinations appear, including MVL shrinking below a VL that has already been set. Directed cases cover the encoded extremes 0 and 127 and the pure-read form.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned XLEN    = 64;
  localparam int unsigned IMM_W   = 7;
  localparam int unsigned LEN_W   = IMM_W + 1;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned CR_W    = 4;

  // Instruction field positions given in MSB-0 numbering, converted below.
  localparam int unsigned IMM_MSB0_LO = 16;
  localparam int unsigned MS_MSB0     = 23;
  localparam int unsigned VS_MSB0     = 24;
  localparam int unsigned VF_MSB0     = 25;
  localparam int unsigned DST_MSB0_LO = 6;
  localparam int unsigned RC_MSB0     = 31;

  // State word positions given in MSB-0 numbering.
  localparam int unsigned ST_VL_MSB0_LO = 7;
  localparam int unsigned ST_VF_MSB0    = 63;
  localparam int unsigned ST_PER_MSB0   = 62;

  localparam int unsigned IMM_HI  = INSN_W - 1 - IMM_MSB0_LO;
  localparam int unsigned MS_POS  = INSN_W - 1 - MS_MSB0;
  localparam int unsigned VS_POS  = INSN_W - 1 - VS_MSB0;
  localparam int unsigned VF_POS  = INSN_W - 1 - VF_MSB0;
  localparam int unsigned DST_HI  = INSN_W - 1 - DST_MSB0_LO;
  localparam int unsigned RC_POS  = INSN_W - 1 - RC_MSB0;

  localparam int unsigned ST_VL_HI  = XLEN - 1 - ST_VL_MSB0_LO;
  localparam int unsigned ST_VF_POS = XLEN - 1 - ST_VF_MSB0;
  localparam int unsigned ST_PER_POS = XLEN - 1 - ST_PER_MSB0;

  typedef struct packed {
    logic [IDX_W-1:0] dest;
    logic [IMM_W-1:0] imm;
    logic             setMvl;
    logic             setVl;
    logic             vertFirst;
    logic             record;
  } vlFields_t;

  typedef struct packed {
    logic fire;
    logic ldMvl;
    logic ldVl;
    logic ldFlags;
    logic wrGpr;
    logic wrCr;
  } vlStrobes_t;

  function automatic vlFields_t splitInsn(input logic [INSN_W-1:0] w);
    vlFields_t f;
    f.imm       = w[IMM_HI -: IMM_W];
    f.setMvl    = w[MS_POS];
    f.setVl     = w[VS_POS];
    f.vertFirst = w[VF_POS];
    f.dest      = w[DST_HI -: IDX_W];
    f.record    = w[RC_POS];
    return f;
  endfunction
endpackage

// File: rtl/vlcfg_ctrl.sv
module vlcfg_ctrl
  import vlcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  vlFields_t  fields,
  output logic       inReady,
  output vlStrobes_t strobes,
  output logic       outValid,
  output logic       gprWe,
  output logic       crWe,
  output logic       stateWe
);
  logic anyLen;

  assign inReady = 1'b1;
  assign anyLen  = fields.setMvl | fields.setVl;

  always_comb begin
    strobes         = '0;
    strobes.fire    = inValid;
    strobes.ldMvl   = inValid & fields.setMvl;
    strobes.ldVl    = inValid & fields.setVl;
    strobes.ldFlags = inValid & anyLen;
    strobes.wrGpr   = inValid & (fields.dest != '0);
    strobes.wrCr    = inValid & fields.record;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      gprWe    <= 1'b0;
      crWe     <= 1'b0;
      stateWe  <= 1'b0;
    end else begin
      outValid <= strobes.fire;
      gprWe    <= strobes.wrGpr;
      crWe     <= strobes.wrCr;
      stateWe  <= strobes.ldFlags;
    end
  end

  // R8
  we_follow_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gprWe || crWe || stateWe) |-> outValid);

  // R8
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid));
endmodule

// File: rtl/vlcfg_dpath.sv
module vlcfg_dpath
  import vlcfg_pkg::*;
#(
  parameter int unsigned RESET_MVL = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vlStrobes_t       strobes,
  input  vlFields_t        fields,
  input  logic [XLEN-1:0]  stateIn,
  output logic [LEN_W-1:0] mvlOut,
  output logic [LEN_W-1:0] vlOut,
  output logic [XLEN-1:0]  stateOut,
  output logic [IDX_W-1:0] gprIdx,
  output logic [XLEN-1:0]  gprData,
  output logic [CR_W-1:0]  crData
);
  logic [LEN_W-1:0] mvlQ, vlQ;
  logic [LEN_W-1:0] reqLen, mvlNext, vlNext;
  logic [XLEN-1:0]  stateNext;
  logic             overflow;

  assign reqLen  = {1'b0, fields.imm} + LEN_W'(1);
  assign mvlNext = strobes.ldMvl ? reqLen : mvlQ;

  always_comb begin
    vlNext = vlQ;
    if (strobes.ldVl)
      vlNext = (reqLen < mvlNext) ? reqLen : mvlNext;
  end

  always_comb begin
    stateNext = stateIn;
    stateNext[ST_VL_HI -: IMM_W] = vlNext[IMM_W-1:0];
    stateNext[ST_VF_POS]  = fields.vertFirst;
    stateNext[ST_PER_POS] = 1'b0;
  end

  assign overflow = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mvlQ     <= LEN_W'(RESET_MVL);
      vlQ      <= '0;
      stateOut <= '0;
      gprIdx   <= '0;
      gprData  <= '0;
      crData   <= '0;
    end else if (strobes.fire) begin
      mvlQ     <= mvlNext;
      vlQ      <= vlNext;
      stateOut <= strobes.ldFlags ? stateNext : stateIn;
      gprIdx   <= fields.dest;
      gprData  <= {{(XLEN-LEN_W){1'b0}}, vlNext};
      crData   <= {1'b0, vlNext != '0, vlNext == '0, overflow};
    end
  end

  assign mvlOut = mvlQ;
  assign vlOut  = vlQ;

  // R3
  vl_within_mvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.ldVl) |-> (vlQ <= mvlQ));

  // R2
  mvl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.ldMvl) |-> (mvlQ != '0));

  // R5
  read_only_keeps_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.fire && !strobes.ldMvl && !strobes.ldVl) |->
      (mvlQ == $past(mvlQ) && vlQ == $past(vlQ)));
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int unsigned RESET_MVL = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] insn,
  input  logic [63:0] stateIn,
  output logic        outValid,
  output logic [7:0]  mvlOut,
  output logic [7:0]  vlOut,
  output logic        stateWe,
  output logic [63:0] stateOut,
  output logic        gprWe,
  output logic [4:0]  gprIdx,
  output logic [63:0] gprData,
  output logic        crWe,
  output logic [3:0]  crData
);
  vlFields_t  fields;
  vlStrobes_t strobes;

  assign fields = splitInsn(insn);

  vlcfg_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .fields   (fields),
    .inReady  (inReady),
    .strobes  (strobes),
    .outValid (outValid),
    .gprWe    (gprWe),
    .crWe     (crWe),
    .stateWe  (stateWe)
  );

  vlcfg_dpath #(.RESET_MVL(RESET_MVL)) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .fields   (fields),
    .stateIn  (stateIn),
    .mvlOut   (mvlOut),
    .vlOut    (vlOut),
    .stateOut (stateOut),
    .gprIdx   (gprIdx),
    .gprData  (gprData),
    .crData   (crData)
  );

  // R4
  persist_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stateWe |-> (stateOut[ST_PER_POS] == 1'b0));

  // R6
  gpr_idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gprWe |-> (gprIdx != '0));

  // R7
  so_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crWe |-> (crData[0] == 1'b0));
endmodule

// File: tb/vlcfg_unit_tb_top.sv
`timescale 1ns/1ps
module vlcfg_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] insn = '0;
  logic [63:0] stateIn = '0;
  logic        outValid, stateWe, gprWe, crWe;
  logic [7:0]  mvlOut, vlOut;
  logic [63:0] stateOut, gprData;
  logic [4:0]  gprIdx;
  logic [3:0]  crData;

  int checks = 0;
  int failures = 0;
  logic [7:0] refMvl, refVl;

  always #4 clk = ~clk;

  vlcfg_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .insn(insn), .stateIn(stateIn), .outValid(outValid),
    .mvlOut(mvlOut), .vlOut(vlOut), .stateWe(stateWe), .stateOut(stateOut),
    .gprWe(gprWe), .gprIdx(gprIdx), .gprData(gprData),
    .crWe(crWe), .crData(crData)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInsn(input logic [6:0] imm, input logic ms,
      input logic vs, input logic vf, input logic [4:0] dst, input logic rc);
    logic [31:0] w = '0;
    w[15:9] = imm; w[8] = ms; w[7] = vs; w[6] = vf; w[25:21] = dst; w[0] = rc;
    return w;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] st);
    logic [7:0]  req;
    logic [63:0] expState;
    logic        anyLen;
    req    = {1'b0, w[15:9]} + 8'd1;
    anyLen = w[8] | w[7];
    if (w[8]) refMvl = req;
    if (w[7]) refVl = (req < refMvl) ? req : refMvl;
    expState = st;
    expState[56:50] = refVl[6:0];
    expState[0] = w[6];
    expState[1] = 1'b0;
    @(negedge clk);
    insn = w; stateIn = st; inValid = 1'b1;
    check("R8 inReady", {63'd0, inReady}, 64'd1);
    @(negedge clk);
    inValid = 1'b0;
    check("R8 outValid", {63'd0, outValid}, 64'd1);
    check("R1/R2 mvl", {56'd0, mvlOut}, {56'd0, refMvl});
    check("R1/R3 vl", {56'd0, vlOut}, {56'd0, refVl});
    check("R4/R5 stateWe", {63'd0, stateWe}, {63'd0, anyLen});
    if (anyLen) check("R4 stateOut", stateOut, expState);
    check("R6 gprWe", {63'd0, gprWe}, {63'd0, w[25:21] != 5'd0});
    if (w[25:21] != 5'd0) begin
      check("R6 gprIdx", {59'd0, gprIdx}, {59'd0, w[25:21]});
      check("R6 gprData", gprData, {56'd0, refVl});
    end
    check("R7 crWe", {63'd0, crWe}, {63'd0, w[0]});
    if (w[0]) check("R7 crData", {60'd0, crData},
                    {60'd0, 1'b0, refVl != 8'd0, refVl == 8'd0, 1'b0});
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    refMvl = 8'd128; refVl = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 mvl", {56'd0, mvlOut}, 64'd128);
    check("R9 vl", {56'd0, vlOut}, 64'd0);
    check("R9 outValid", {63'd0, outValid}, 64'd0);
    check("R9 we", {61'd0, gprWe, crWe, stateWe}, 64'd0);

    // R5 pure read after reset: VL 0, eq set
    issue(mkInsn(7'd5, 1'b0, 1'b0, 1'b1, 5'd3, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF);
    // R1 encoded 0 -> length 1
    issue(mkInsn(7'd0, 1'b0, 1'b1, 1'b0, 5'd1, 1'b1), 64'h0);
    // R10 encoded 127 -> 128, state field 0
    issue(mkInsn(7'd127, 1'b1, 1'b1, 1'b1, 5'd7, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 state field", {57'd0, stateOut[56:50]}, 64'd0);
    // R2 shrink MVL only: VL stays 128
    issue(mkInsn(7'd15, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1), 64'h1234_5678_9ABC_DEF3);
    // R3 clamp to MVL 16
    issue(mkInsn(7'd99, 1'b0, 1'b1, 1'b1, 5'd31, 1'b0), 64'h0);
    // R3 set both in same instruction, min uses new MVL
    issue(mkInsn(7'd40, 1'b1, 1'b1, 1'b0, 5'd2, 1'b1), 64'h3);

    // R8 idle edge clears valid and enables
    @(negedge clk);
    check("R8 idle outValid", {63'd0, outValid}, 64'd0);
    check("R8 idle we", {61'd0, gprWe, crWe, stateWe}, 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [63:0] st;
      w  = $urandom;
      st = {$urandom, $urandom};
      issue(w, st);
      if (($urandom % 4) == 0) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule